// File: doc/BRIEF.md
# Dual-Path Delta-Sigma Bitstream Filter

This block takes the one-bit stream of an external second-order delta-sigma modulator and filters it in two independent paths. The block runs on the modulator clock and samples one bit per clock. The accuracy path is a third-order sinc decimator with a response of ((1 - z^-N)/(1 - z^-1))^3. N defaults to 256. Every N clocks it delivers a signed 16-bit conversion word for a control loop.

The protection path is a second-order sinc decimator with a short window of 16 clocks. Each of its samples is compared against a signed upper limit and a signed lower limit. A sample outside the limits raises an overcurrent flag within a few tens of clocks. The flag can latch until it is cleared. It can also release by itself after a programmable number of in-range samples.

Both paths hold back their first results after reset, because the integrators start from zero. The accuracy path marks a word as trustworthy through a settled level. The protection path ignores its early samples.

Top module: `dsf_dualpath`

## Requirements
- R1: Input bit 1 counts as +1 and bit 0 as -1. For a stream whose ones density is d, the word equals 65536*d - 32768, clamped to 32767 at the top. A repeating 16-clock pattern of k ones gives k*4096 - 32768. The word is exact from the fourth word whose whole window lies after the density change.
- R2: acc_strobe is a one-clock pulse. It repeats exactly every 256 clocks (2^OSR_LOG2), and acc_word changes only together with it.
- R3: acc_settled is low after reset and stays low through the first three acc_strobe pulses. It rises together with the fourth pulse and then stays high until reset.
- R4: fast_strobe is a one-clock pulse every 16 clocks. fast_word is signed and equals 256*d - 128, so a 16-clock pattern of k ones gives 16*k - 128. The value is exact from the third sample after a change, and fast_word always lies within -128..128.
- R5: oc_flag rises on the clock after a fast_strobe whose fast_word is strictly above thr_hi or strictly below thr_lo; both limits are signed. A value equal to a limit does not trip. The first two fast samples after reset never trip.
- R6: With oc_auto = 0, oc_flag stays high until a clock edge where oc_clear is 1 and no violation arrives at that edge. A violation at that edge keeps the flag high.
- R7: With oc_auto = 1, oc_flag falls after oc_hold consecutive in-range fast samples. A violation restarts the count, and an oc_hold of 0 behaves like 1.
- R8: A step from a half-density stream to all ones, with thr_hi = 100, raises oc_flag within 56 clocks of the first one bit.
- R9: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one bitstream sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Modulator data bit |
| thr_hi | input | 2*FAST_LOG2+2 | Signed upper limit for the fast path |
| thr_lo | input | 2*FAST_LOG2+2 | Signed lower limit for the fast path |
| oc_auto | input | 1 | 0: latching flag, 1: self-releasing flag |
| oc_hold | input | HOLD_W | In-range fast samples needed to release in auto mode |
| oc_clear | input | 1 | Clears the flag when no violation arrives at that edge |
| acc_word | output | 16 | Signed accuracy-path conversion word |
| acc_strobe | output | 1 | One-clock pulse marking a new acc_word |
| acc_settled | output | 1 | High once accuracy words have fully settled |
| fast_word | output | 2*FAST_LOG2+2 | Signed fast-path sample |
| fast_strobe | output | 1 | One-clock pulse marking a new fast_word |
| oc_flag | output | 1 | Overcurrent indication |

## Verification
A corrupted integrator or differentiator register shows up as wrong conversion words. Because the three differences cancel any offset up to quadratic order, the error lasts for at most three words, about 768 clocks, and then disappears. A wrong phase counter shows up at the next strobe as a spacing other than 256 or 16 clocks. A wrong flag or hold counter shows up one clock after the fast sample that should have set or released the flag. The bench therefore sweeps every 16-clock density from 0 to 16 ones and checks each word exactly. It also tracks the flag sample by sample in auto mode and probes both limits at equality and one step past.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int WORD_W        = 16;
    localparam int DEF_OSR_LOG2  = 8;
    localparam int DEF_FAST_LOG2 = 4;
    localparam int ACC_ORDER     = 3;
    localparam int FAST_ORDER    = 2;

    typedef logic signed [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  stb;
        logic  settled;
        word_t word;
    } acc_out_t;

    typedef enum logic {
        OC_LATCH = 1'b0,
        OC_TIMED = 1'b1
    } oc_mode_e;

    // Clamp a wide signed value into the conversion word range.
    function automatic word_t clamp_word(input logic signed [33:0] v);
        logic signed [33:0] top;
        logic signed [33:0] bot;
        top = (34'sd1 <<< (WORD_W - 1)) - 34'sd1;
        bot = -(34'sd1 <<< (WORD_W - 1));
        if (v > top)      return word_t'(top);
        else if (v < bot) return word_t'(bot);
        else              return word_t'(v);
    endfunction

    // Scale the unsigned ones-count sum and move zero to mid-scale.
    function automatic word_t center_word(input logic [31:0] raw, input int shift);
        logic signed [33:0] v;
        v = $signed({2'b00, raw >> shift}) - (34'sd1 <<< (WORD_W - 1));
        return clamp_word(v);
    endfunction

endpackage

// File: rtl/dsf_sinc_core.sv
// Generic sinc^ORDER decimator: ORDER integrators at the input rate,
// ORDER differences at the decimated rate. Unsigned wrap-around math.
module dsf_sinc_core #(
    parameter int ORDER = 3,
    parameter int RLOG2 = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bit_in,
    output logic [ORDER*RLOG2:0]       raw,
    output logic                       tick,
    output logic                       settled
);
    localparam int W  = ORDER * RLOG2 + 1;
    localparam int CW = $clog2(ORDER + 1);

    logic [W-1:0]     integ [ORDER];
    logic [W-1:0]     dly   [ORDER];
    logic [W-1:0]     chain [ORDER+1];
    logic [RLOG2-1:0] phase;
    logic [CW-1:0]    n_out;

    generate
        for (genvar g = 0; g < ORDER; g++) begin : g_integ
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) integ[g] <= '0;
                    else     integ[g] <= integ[g] + {{(W-1){1'b0}}, bit_in};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) integ[g] <= '0;
                    else     integ[g] <= integ[g] + integ[g-1];
                end
            end
        end

        assign chain[0] = integ[ORDER-1];

        for (genvar g = 0; g < ORDER; g++) begin : g_comb
            assign chain[g+1] = chain[g] - dly[g];
            always_ff @(posedge clk) begin
                if (rst)       dly[g] <= '0;
                else if (tick) dly[g] <= chain[g];
            end
        end
    endgenerate

    assign tick    = (phase == {RLOG2{1'b1}});
    assign raw     = chain[ORDER];
    assign settled = (n_out == CW'(ORDER));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            n_out <= '0;
        end else begin
            phase <= phase + 1'b1;
            if (tick && !settled) n_out <= n_out + 1'b1;
        end
    end

endmodule

// File: rtl/dsf_oc_monitor.sv
module dsf_oc_monitor
    import dsf_pkg::*;
#(
    parameter int VW     = 10,
    parameter int HOLD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [VW-1:0] val,
    input  logic                 stb,
    input  logic                 armed,
    input  logic signed [VW-1:0] thr_hi,
    input  logic signed [VW-1:0] thr_lo,
    input  logic                 auto_mode,
    input  logic [HOLD_W-1:0]    hold_len,
    input  logic                 clear,
    output logic                 flag
);
    oc_mode_e          mode;
    logic              outside;
    logic              viol;
    logic              calm;
    logic [HOLD_W-1:0] run;
    logic [HOLD_W:0]   run_next;

    assign mode     = oc_mode_e'(auto_mode);
    assign outside  = (val > thr_hi) || (val < thr_lo);
    assign viol     = stb && armed && outside;
    assign calm     = stb && armed && !outside;
    assign run_next = {1'b0, run} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            run  <= '0;
        end else if (viol) begin
            flag <= 1'b1;
            run  <= '0;
        end else if (clear) begin
            flag <= 1'b0;
            run  <= '0;
        end else if (mode == OC_TIMED && flag && calm) begin
            if (run_next >= {1'b0, hold_len}) begin
                flag <= 1'b0;
                run  <= '0;
            end else begin
                run <= run_next[HOLD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dsf_dualpath.sv
module dsf_dualpath
    import dsf_pkg::*;
#(
    parameter int OSR_LOG2  = DEF_OSR_LOG2,
    parameter int FAST_LOG2 = DEF_FAST_LOG2,
    parameter int HOLD_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bit_in,
    input  logic signed [2*FAST_LOG2+1:0]  thr_hi,
    input  logic signed [2*FAST_LOG2+1:0]  thr_lo,
    input  logic                           oc_auto,
    input  logic [HOLD_W-1:0]              oc_hold,
    input  logic                           oc_clear,
    output logic signed [WORD_W-1:0]       acc_word,
    output logic                           acc_strobe,
    output logic                           acc_settled,
    output logic signed [2*FAST_LOG2+1:0]  fast_word,
    output logic                           fast_strobe,
    output logic                           oc_flag
);
    localparam int ACC_W    = ACC_ORDER * OSR_LOG2 + 1;
    localparam int FAST_RW  = FAST_ORDER * FAST_LOG2 + 1;
    localparam int FW       = FAST_RW + 1;
    localparam int SHIFT    = ACC_ORDER * OSR_LOG2 - WORD_W;
    localparam int FAST_MID = 1 << (FAST_ORDER * FAST_LOG2 - 1);

    logic [ACC_W-1:0]    acc_raw;
    logic                acc_tick;
    logic                acc_ok;
    logic [FAST_RW-1:0]  fast_raw;
    logic                fast_tick;
    logic                fast_ok;
    logic signed [FW-1:0] fast_val;

    acc_out_t             acc_q;
    logic signed [FW-1:0] fast_q;
    logic                 fast_stb_q;
    logic                 fast_ok_q;

    dsf_sinc_core #(.ORDER(ACC_ORDER), .RLOG2(OSR_LOG2)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .raw     (acc_raw),
        .tick    (acc_tick),
        .settled (acc_ok)
    );

    dsf_sinc_core #(.ORDER(FAST_ORDER), .RLOG2(FAST_LOG2)) u_fast (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .raw     (fast_raw),
        .tick    (fast_tick),
        .settled (fast_ok)
    );

    assign fast_val = $signed({1'b0, fast_raw}) - $signed(FW'(FAST_MID));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            fast_q     <= '0;
            fast_stb_q <= 1'b0;
            fast_ok_q  <= 1'b0;
        end else begin
            acc_q.stb  <= acc_tick;
            fast_stb_q <= fast_tick;
            if (acc_tick) begin
                acc_q.word    <= center_word(32'(acc_raw), SHIFT);
                acc_q.settled <= acc_ok;
            end
            if (fast_tick) begin
                fast_q    <= fast_val;
                fast_ok_q <= fast_ok;
            end
        end
    end

    dsf_oc_monitor #(.VW(FW), .HOLD_W(HOLD_W)) u_oc (
        .clk       (clk),
        .rst       (rst),
        .val       (fast_q),
        .stb       (fast_stb_q),
        .armed     (fast_ok_q),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .auto_mode (oc_auto),
        .hold_len  (oc_hold),
        .clear     (oc_clear),
        .flag      (oc_flag)
    );

    assign acc_word    = acc_q.word;
    assign acc_strobe  = acc_q.stb;
    assign acc_settled = acc_q.settled;
    assign fast_word   = fast_q;
    assign fast_strobe = fast_stb_q;

endmodule

// File: rtl/dsf_dualpath_chk.sv
module dsf_dualpath_chk #(
    parameter int OSR_LOG2  = 8,
    parameter int FAST_LOG2 = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          acc_strobe,
    input logic                          acc_settled,
    input logic                          fast_strobe,
    input logic signed [2*FAST_LOG2+1:0] fast_word,
    input logic signed [2*FAST_LOG2+1:0] thr_hi,
    input logic signed [2*FAST_LOG2+1:0] thr_lo,
    input logic                          oc_auto,
    input logic                          oc_clear,
    input logic                          oc_flag
);
    localparam int FW   = 2 * FAST_LOG2 + 2;
    localparam int FMAX = 1 << (2 * FAST_LOG2 - 1);

    logic [OSR_LOG2:0]  a_gap;
    logic               a_seen;
    logic [FAST_LOG2:0] f_gap;
    logic               f_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_gap  <= '0;
            a_seen <= 1'b0;
            f_gap  <= '0;
            f_seen <= 1'b0;
        end else begin
            if (acc_strobe) begin a_gap <= '0; a_seen <= 1'b1; end
            else            a_gap <= a_gap + 1'b1;
            if (fast_strobe) begin f_gap <= '0; f_seen <= 1'b1; end
            else             f_gap <= f_gap + 1'b1;
        end
    end

    assert_acc_period_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_strobe && a_seen) |-> (a_gap == (OSR_LOG2+1)'((1 << OSR_LOG2) - 1)));

    assert_fast_period_R4: assert property (@(posedge clk) disable iff (rst)
        (fast_strobe && f_seen) |-> (f_gap == (FAST_LOG2+1)'((1 << FAST_LOG2) - 1)));

    assert_fast_range_R4: assert property (@(posedge clk) disable iff (rst)
        fast_strobe |-> ((fast_word <= FW'(FMAX)) && (fast_word >= -FW'(FMAX))));

    assert_settled_hold_R3: assert property (@(posedge clk) disable iff (rst)
        acc_settled |=> acc_settled);

    assert_settled_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_settled) |-> acc_strobe);

    assert_trip_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_flag) |-> ($past(fast_strobe) &&
            (($signed($past(fast_word)) > $signed($past(thr_hi))) ||
             ($signed($past(fast_word)) < $signed($past(thr_lo))))));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (oc_flag && !oc_auto && !oc_clear) |=> oc_flag);

endmodule

bind dsf_dualpath dsf_dualpath_chk #(
    .OSR_LOG2  (OSR_LOG2),
    .FAST_LOG2 (FAST_LOG2)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_strobe  (acc_strobe),
    .acc_settled (acc_settled),
    .fast_strobe (fast_strobe),
    .fast_word   (fast_word),
    .thr_hi      (thr_hi),
    .thr_lo      (thr_lo),
    .oc_auto     (oc_auto),
    .oc_clear    (oc_clear),
    .oc_flag     (oc_flag)
);

// File: tb/dsf_dualpath_tb.sv
`timescale 1ns/1ps
module dsf_dualpath_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bit_in = 1'b0;
    logic signed [9:0] thr_hi = 10'sd100;
    logic signed [9:0] thr_lo = -10'sd100;
    logic              oc_auto = 1'b0;
    logic [7:0]        oc_hold = 8'd3;
    logic              oc_clear = 1'b0;
    logic signed [15:0] acc_word;
    logic              acc_strobe;
    logic              acc_settled;
    logic signed [9:0] fast_word;
    logic              fast_strobe;
    logic              oc_flag;

    int n_chk = 0;
    int n_bad = 0;
    int dens  = 8;
    int cyc   = 0;

    always #5 clk = ~clk;

    dsf_dualpath u_dut (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .thr_hi(thr_hi), .thr_lo(thr_lo),
        .oc_auto(oc_auto), .oc_hold(oc_hold), .oc_clear(oc_clear),
        .acc_word(acc_word), .acc_strobe(acc_strobe), .acc_settled(acc_settled),
        .fast_word(fast_word), .fast_strobe(fast_strobe), .oc_flag(oc_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Periodic 16-clock pattern with dens ones, driven away from the edge.
    always @(negedge clk) begin
        bit_in = ((cyc % 16) < dens);
        cyc    = cyc + 1;
    end

    // Port monitor: strobe spacing, settled timing, last fast sample.
    int mcyc = 0;
    int last_a = -1;
    int last_f = -1;
    int a_cnt = 0;
    int last_fast = 0;
    always @(negedge clk) begin
        mcyc++;
        if (!rst) begin
            if (acc_strobe) begin
                a_cnt++;
                if (last_a >= 0) check(mcyc - last_a == 256, "R2 acc spacing", mcyc - last_a, 256);
                last_a = mcyc;
                if (a_cnt <= 4)
                    check(acc_settled == (a_cnt == 4), "R3 settled at strobe", int'(acc_settled), int'(a_cnt == 4));
            end
            if (fast_strobe) begin
                if (last_f >= 0) check(mcyc - last_f == 16, "R4 fast spacing", mcyc - last_f, 16);
                last_f = mcyc;
                last_fast = int'(fast_word);
            end
        end
    end

    // Auto-mode flag model computed from observed fast samples (R7).
    bit model_on = 0;
    bit m_pend = 0;
    bit m_exp = 0;
    int m_run = 0;
    always @(negedge clk) begin
        if (model_on) begin
            if (m_pend) begin
                check(oc_flag == m_exp, "R7 auto flag", int'(oc_flag), int'(m_exp));
                m_pend = 0;
            end
            if (fast_strobe) begin
                if (int'(fast_word) > int'(thr_hi) || int'(fast_word) < int'(thr_lo)) begin
                    m_exp = 1; m_run = 0;
                end else if (m_exp) begin
                    m_run++;
                    if (m_run >= int'(oc_hold)) begin m_exp = 0; m_run = 0; end
                end
                m_pend = 1;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic wait_acc();
        do @(negedge clk); while (!acc_strobe);
    endtask

    task automatic pulse_clear();
        @(negedge clk) oc_clear = 1'b1;
        @(negedge clk) oc_clear = 1'b0;
    endtask

    initial begin : main
        int lat;
        bit tripped;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(acc_word == 0 && acc_strobe == 0 && acc_settled == 0, "R9 acc outputs", int'(acc_word), 0);
        check(fast_word == 0 && fast_strobe == 0 && oc_flag == 0, "R9 fast outputs", int'(oc_flag), 0);
        rst = 1'b0;

        // R5: the first fast samples see zero history and must not trip.
        tripped = 0;
        repeat (64) begin @(negedge clk); if (oc_flag) tripped = 1; end
        check(!tripped, "R5 startup suppressed", int'(tripped), 0);

        // R1 / R4: sweep every 16-clock density.
        thr_hi = 10'sd200;
        thr_lo = -10'sd200;
        for (int k = 0; k <= 16; k++) begin
            int exp_w;
            dens = k;
            repeat (4) wait_acc();
            exp_w = (k == 16) ? 32767 : k * 4096 - 32768;
            check(int'(acc_word) == exp_w, "R1 density word", int'(acc_word), exp_w);
            check(last_fast == 16 * k - 128, "R4 fast value", last_fast, 16 * k - 128);
        end
        check(acc_settled == 1'b1, "R3 settled stays high", int'(acc_settled), 1);

        // Return to mid-scale before arming the limits.
        dens = 8;
        repeat (80) @(negedge clk);
        thr_hi = 10'sd100;
        thr_lo = -10'sd100;
        repeat (64) @(negedge clk);
        check(oc_flag == 0, "R5 in range no trip", int'(oc_flag), 0);

        // R8: latency of a full-scale step.
        dens = 16;
        lat = 0;
        while (!oc_flag && lat < 200) begin @(negedge clk); lat++; end
        check(lat <= 56, "R8 trip latency", lat, 56);

        // R6: latching mode holds, clear releases.
        dens = 8;
        repeat (100) @(negedge clk);
        check(oc_flag == 1, "R6 latch holds", int'(oc_flag), 1);
        pulse_clear();
        check(oc_flag == 0, "R6 clear releases", int'(oc_flag), 0);

        // R5: lower limit trips.
        dens = 0;
        repeat (80) @(negedge clk);
        check(oc_flag == 1, "R5 low trip", int'(oc_flag), 1);
        dens = 8;
        repeat (64) @(negedge clk);
        pulse_clear();
        check(oc_flag == 0, "R6 clear after low", int'(oc_flag), 0);

        // R5: upper limit at equality and one step below.
        thr_hi = 10'sd96;
        dens = 14;
        repeat (100) @(negedge clk);
        check(oc_flag == 0, "R5 equal to high limit", int'(oc_flag), 0);
        thr_hi = 10'sd95;
        repeat (40) @(negedge clk);
        check(oc_flag == 1, "R5 above high limit", int'(oc_flag), 1);
        thr_hi = 10'sd100;
        dens = 8;
        repeat (64) @(negedge clk);
        pulse_clear();

        // R5: lower limit at equality and one step above.
        thr_lo = -10'sd96;
        dens = 2;
        repeat (100) @(negedge clk);
        check(oc_flag == 0, "R5 equal to low limit", int'(oc_flag), 0);
        thr_lo = -10'sd95;
        repeat (40) @(negedge clk);
        check(oc_flag == 1, "R5 below low limit", int'(oc_flag), 1);
        thr_lo = -10'sd100;
        dens = 8;
        repeat (64) @(negedge clk);
        pulse_clear();
        check(oc_flag == 0, "R6 clear after boundary", int'(oc_flag), 0);

        // R7: self-releasing mode, tracked sample by sample.
        oc_auto = 1'b1;
        oc_hold = 8'd3;
        @(negedge clk);
        model_on = 1;
        dens = 16;
        repeat (80) @(negedge clk);
        check(oc_flag == 1, "R7 auto trips", int'(oc_flag), 1);
        dens = 8;
        repeat (200) @(negedge clk);
        check(oc_flag == 0, "R7 auto releases", int'(oc_flag), 0);
        model_on = 0;

        finish_run();
    end

endmodule